// File: doc/BRIEF.md
# Hypercube Broadcast Step Scheduler

This block runs on every node of a binary n-cube. It tells the node what to do in each step of a one-port broadcast along a spanning tree rooted at a chosen node. A start pulse captures the node's own index and the root index. After that, each step strobe moves the schedule one dimension down, from the highest link to link 0. For every step the block issues one of three actions: a receive request, a send request, or nothing. A request comes with the dimension of the link it uses. The link interface moves the data and reports arrival with `rx_ok`.

The schedule depends only on the XOR of the node index and the root index. This makes every node act as if the root were node 0. The lowest set bit of that XOR selects the step in which the node receives. The node forwards on every dimension below that bit. The root is handled as if its XOR had a one just above the top dimension. So the root never receives and sends on every dimension. If a forwarding step comes before the message has arrived, the block flags an error and does not send. After the dimension-0 step the block raises `done`.

Top module: `hcube_bcast_sched`

## Requirements
- R1: After reset, `send_req`, `recv_req`, `busy`, `done`, `err` and `link_dim` are all 0.
- R2: A `start` pulse arms the schedule and raises `busy`. The schedule then accepts exactly DIM step strobes. The strobe for dimension 0 clears `busy` and raises `done`, in the same cycle as that step's request.
- R3: Step strobes take the dimensions in falling order, DIM-1 down to 0. Each request appears one cycle after its strobe, as a single-cycle pulse, with `link_dim` equal to that step's dimension.
- R4: A node whose relative index r = node_id XOR root_id is nonzero issues `recv_req` in exactly one step: the step whose dimension equals the index of the lowest set bit of r.
- R5: The root (r = 0) never issues `recv_req`. With its message held from `start`, it issues `send_req` on every dimension.
- R6: A node issues `send_req` at dimension d only if the lowest set bit of r lies strictly above d (for the root, at position DIM). It also needs to have seen `rx_ok` since `start`. In all other steps it issues nothing.
- R7: No step produces both `send_req` and `recv_req`.
- R8: If a send step comes while the message is not held, `err` rises, no `send_req` is issued, and `err` stays set until the next `start`.
- R9: Step strobes while `busy` is low produce no request and leave `done` and `err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a broadcast schedule; captures node_id and root_id |
| step | input | 1 | Step strobe, one per broadcast step |
| node_id | input | DIM | Index of this node |
| root_id | input | DIM | Index of the broadcast root |
| rx_ok | input | 1 | Link interface reports the message has arrived |
| send_req | output | 1 | Send on link `link_dim` this step |
| recv_req | output | 1 | Receive on link `link_dim` this step |
| link_dim | output | max(1,clog2(DIM)) | Dimension of the requested link |
| busy | output | 1 | Schedule armed, steps remaining |
| done | output | 1 | All DIM steps processed |
| err | output | 1 | A send step came before the message arrived |

## Verification
The assertions assume that `start` and `step` are never high in the same cycle. They also assume `rx_ok` arrives only after a receive request, or not at all. The bench drives every input at the falling edge. It keeps `start` and `step` in separate cycles, and it pulses `rx_ok` only after it has seen `recv_req`. A few runs withhold `rx_ok` on purpose to exercise the error path. Node and root pairs are drawn at random from a fixed seed. Directed cases are added for the root, for the node across the top link, for node 1, and for strobes sent while idle.

// File: rtl/hcube_bcast_sched.sv
module hcube_bcast_sched #(
  parameter int DIM = 4,
  localparam int LW = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int PW = $clog2(DIM + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           step,
  input  logic [DIM-1:0] node_id,
  input  logic [DIM-1:0] root_id,
  input  logic           rx_ok,
  output logic           send_req,
  output logic           recv_req,
  output logic [LW-1:0]  link_dim,
  output logic           busy,
  output logic           done,
  output logic           err
);

  logic [DIM-1:0] rel_in, rel_q;
  logic [PW-1:0]  low_in, low_q, cur_ext;
  logic [LW-1:0]  cur_q;
  logic           have_q;
  logic           is_rx, is_tx;

  assign rel_in = node_id ^ root_id;

  always_comb begin
    low_in = PW'(DIM);
    for (int i = DIM - 1; i >= 0; i--)
      if (rel_in[i]) low_in = PW'(i);
  end

  assign cur_ext = PW'(cur_q);
  assign is_rx   = (low_q == cur_ext);
  assign is_tx   = (low_q >  cur_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q    <= '0;
      low_q    <= '0;
      cur_q    <= '0;
      have_q   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      send_req <= 1'b0;
      recv_req <= 1'b0;
      link_dim <= '0;
    end else begin
      send_req <= 1'b0;
      recv_req <= 1'b0;
      if (rx_ok && busy) have_q <= 1'b1;
      if (start) begin
        rel_q    <= rel_in;
        low_q    <= low_in;
        cur_q    <= LW'(DIM - 1);
        have_q   <= (rel_in == '0);
        busy     <= 1'b1;
        done     <= 1'b0;
        err      <= 1'b0;
        link_dim <= '0;
      end else if (step && busy) begin
        link_dim <= cur_q;
        if (is_rx) begin
          recv_req <= 1'b1;
        end else if (is_tx) begin
          if (have_q) send_req <= 1'b1;
          else        err      <= 1'b1;
        end
        if (cur_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur_q <= cur_q - 1'b1;
        end
      end
    end
  end

  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_req && recv_req));

  // R4
  recv_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv_req |-> rel_q[link_dim]);

  // R5
  root_no_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recv_req |-> (rel_q != '0));

  // R8
  send_holds_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> $past(have_q));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  link_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req || recv_req) |-> (int'(link_dim) < DIM));

endmodule

// File: tb/hcube_bcast_sched_tb.sv
module hcube_bcast_sched_tb_top;
  localparam int DIM = 4;
  localparam int LW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, step = 1'b0, rx_ok = 1'b0;
  logic [DIM-1:0] node_id = '0, root_id = '0;
  logic send_req, recv_req, busy, done, err;
  logic [LW-1:0] link_dim;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  hcube_bcast_sched #(.DIM(DIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .node_id(node_id), .root_id(root_id), .rx_ok(rx_ok),
    .send_req(send_req), .recv_req(recv_req), .link_dim(link_dim),
    .busy(busy), .done(done), .err(err));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [DIM-1:0] r);
    int l = DIM;
    for (int i = DIM - 1; i >= 0; i--) if (r[i]) l = i;
    return l;
  endfunction

  task automatic pulse_start(input logic [DIM-1:0] nd, input logic [DIM-1:0] rt);
    @(negedge clk);
    node_id = nd; root_id = rt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
  endtask

  task automatic do_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic run_bcast(input logic [DIM-1:0] nd, input logic [DIM-1:0] rt,
                           input bit give_rx);
    int lb;
    bit has;
    bit e;
    lb  = low_bit(nd ^ rt);
    has = (lb == DIM);
    e   = 1'b0;
    pulse_start(nd, rt);
    for (int d = DIM - 1; d >= 0; d--) begin
      bit xr, xs;
      xr = (lb == d);
      xs = (lb > d) && has;
      if (lb > d && !has) e = 1'b1;
      do_step();
      check("R4 recv_req", int'(recv_req), int'(xr));
      check("R6 send_req", int'(send_req), int'(xs));
      check("R7 one port", int'(send_req & recv_req), 0);
      if (xr || xs) check("R3 link_dim", int'(link_dim), d);
      check("R8 err", int'(err), int'(e));
      check("R2 done timing", int'(done), int'(d == 0));
      if (xr && give_rx) begin
        rx_ok = 1'b1;
        @(negedge clk);
        rx_ok = 1'b0;
        has = 1'b1;
      end
    end
    check("R2 busy cleared", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 send_req", int'(send_req), 0);
    check("R1 recv_req", int'(recv_req), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 link_dim", int'(link_dim), 0);
    rst_n = 1'b1;

    // R9: steps while idle
    do_step();
    check("R9 idle send", int'(send_req), 0);
    check("R9 idle recv", int'(recv_req), 0);
    check("R9 idle done", int'(done), 0);

    // R5: root sends on every link
    run_bcast(4'b0000, 4'b0000, 1'b1);
    // node across the top link, node 1, node with the top bit only
    run_bcast(4'b1000, 4'b0000, 1'b1);
    run_bcast(4'b0001, 4'b0000, 1'b1);
    run_bcast(4'b0110, 4'b0110, 1'b1);
    run_bcast(4'b0101, 4'b1101, 1'b1);

    // R9: steps after done
    do_step();
    check("R9 post-done send", int'(send_req), 0);
    check("R9 post-done recv", int'(recv_req), 0);
    check("R9 post-done done", int'(done), 1);

    // R8: withheld rx_ok
    run_bcast(4'b1000, 4'b0000, 1'b0);
    do_step();
    check("R8 err held while idle", int'(err), 1);
    pulse_start(4'b0011, 4'b0011);
    check("R8 err cleared by start", int'(err), 0);
    for (int d = 0; d < DIM; d++) do_step();

    // random pairs with a fixed seed
    void'($urandom(32'h5EED));
    for (int t = 0; t < 40; t++) begin
      logic [DIM-1:0] a, b;
      a = DIM'($urandom);
      b = DIM'($urandom);
      run_bcast(a, b, ($urandom % 8) != 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule